// File: doc/BRIEF.md
# Dual-Clock Interprocessor Mailbox

This block lets two processors that run on unrelated clocks exchange 32-bit words and doorbell events. Each processor owns one side of the block, A or B. Each side has its own clock, its own reset, a simple select/write register bus and an interrupt line. Every side has the same register bank. A word written into transmit slot n on one side is handed across the clock boundary and shows up in receive slot n on the opposite side. When the receiver reads that slot, an acknowledge travels back to the sender.

Every channel moves one word at a time. A full flag blocks the transmit slot until the peer has read the word. A second write made while the slot is blocked is dropped, and an overflow flag records it. Doorbells carry no data. Ringing one raises a pending flag on the far side, and the receiver clears that flag by writing a one to it. One interrupt line per side combines the receive-full, acknowledge-pending and doorbell-pending flags, each gated by its own enable bit.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, STATUS (word address 16) reads 0x00000000 on side A and 0x80000000 on side B. ENABLE (address 17) reads 0 on both sides, and both interrupt outputs are low.
- R2: A write to TX slot n (address 0+n) is delivered unchanged to RX slot n (address 8+n) on the other side. The receiver's STATUS[n] (rx full) then reads 1. The sender's STATUS[4+n] (tx full) reads 1 from the cycle after the write.
- R3: Reading RX slot n while it is full clears the receiver's STATUS[n]. After that, the sender's STATUS[4+n] clears and its STATUS[8+n] (acknowledge pending) sets.
- R4: Reading RX slot n while it is empty returns the last word received and sends no acknowledge. The sender's STATUS[8+n] stays 0.
- R5: A write to TX slot n while STATUS[4+n] is 1 is discarded, so the word first delivered is still the one read on the far side. The write also sets the sender's sticky overflow bit STATUS[16+n].
- R6: Writing 1 to STATUS bits 8..11, 12..15 or 16..19 clears those flags. Writing 0 leaves them unchanged. A set event in the same cycle as a clear wins.
- R7: Writing RING (address 18) with bit n set raises STATUS[12+n] (doorbell pending) on the other side. It changes no data slot and no full flag.
- R8: The interrupt output is high exactly when (STATUS[3:0] & ENABLE[3:0]), (STATUS[11:8] & ENABLE[7:4]) or (STATUS[15:12] & ENABLE[11:8]) is non-zero.
- R9: STATUS[31] reads the side-role parameter: 0 on side A and 1 on side B.
- R10: Channels in the two directions, and the different channel numbers, run independently. Words sent at the same time in both directions all arrive intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Side A clock |
| rst_a_n | input | 1 | Side A asynchronous reset, active low |
| a_cs | input | 1 | Side A access strobe |
| a_we | input | 1 | Side A write (1) or read (0) |
| a_addr | input | 5 | Side A word address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data (combinational) |
| a_irq | output | 1 | Side A interrupt |
| clk_b | input | 1 | Side B clock |
| rst_b_n | input | 1 | Side B asynchronous reset, active low |
| b_cs | input | 1 | Side B access strobe |
| b_we | input | 1 | Side B write (1) or read (0) |
| b_addr | input | 5 | Side B word address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data (combinational) |
| b_irq | output | 1 | Side B interrupt |

## Verification
The assertions check on every cycle that a tx full flag rises only from a load, and that an rx full flag falls only after a read. They also check that the held transmit word stays frozen while its slot is blocked, that a doorbell flag drops only on a clear, and that an acknowledge flag rises only on a returned handshake. The bench scenarios are the only place where end-to-end effects show: a word arriving intact on the far side, an overflow write leaving the delivered word untouched, an empty read sending no acknowledge, and the interrupt following the enables.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int unsigned MBX_AW       = 5;
   localparam int unsigned ADR_TX_BASE  = 0;
   localparam int unsigned ADR_RX_BASE  = 8;
   localparam int unsigned ADR_STAT     = 16;
   localparam int unsigned ADR_EN       = 17;
   localparam int unsigned ADR_RING     = 18;
   // status field index; field k occupies bits [k*NCH +: NCH]
   localparam int unsigned FLD_RXF = 0;
   localparam int unsigned FLD_TXF = 1;
   localparam int unsigned FLD_ACK = 2;
   localparam int unsigned FLD_DB  = 3;
   localparam int unsigned FLD_OVF = 4;
   localparam int unsigned NFLD    = 5;
endpackage

// File: rtl/mbx_sync2.sv
module mbx_sync2 #(
   parameter int unsigned W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] meta;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta <= '0;
         q    <= '0;
      end else begin
         meta <= d;
         q    <= meta;
      end
   end
endmodule

// File: rtl/mbx_xfer.sv
module mbx_xfer #(
   parameter int unsigned DW = 32
) (
   input  logic          s_clk,
   input  logic          s_rst_n,
   input  logic          s_load,
   input  logic [DW-1:0] s_data,
   output logic          s_busy,
   output logic          s_done,
   output logic [DW-1:0] s_hold,
   input  logic          r_clk,
   input  logic          r_rst_n,
   input  logic          r_take,
   output logic          r_full,
   output logic [DW-1:0] r_data
);
   logic req_t, req_r, req_seen;
   logic ack_t, ack_s, ack_seen;

   if (DW < 1) begin : g_bad_dw
      $error("mbx_xfer: DW must be at least 1");
   end

   mbx_sync2 #(.W(1)) u_req_sync (.clk(r_clk), .rst_n(r_rst_n), .d(req_t), .q(req_r));
   mbx_sync2 #(.W(1)) u_ack_sync (.clk(s_clk), .rst_n(s_rst_n), .d(ack_t), .q(ack_s));

   // sending side: hold the word and flip the request toggle
   always_ff @(posedge s_clk or negedge s_rst_n) begin
      if (!s_rst_n) begin
         req_t    <= 1'b0;
         s_busy   <= 1'b0;
         s_done   <= 1'b0;
         s_hold   <= '0;
         ack_seen <= 1'b0;
      end else begin
         s_done   <= 1'b0;
         ack_seen <= ack_s;
         if (ack_s != ack_seen) begin
            s_busy <= 1'b0;
            s_done <= 1'b1;
         end else if (s_load && !s_busy) begin
            s_hold <= s_data;
            req_t  <= ~req_t;
            s_busy <= 1'b1;
         end
      end
   end

   // receiving side: capture on request edge, acknowledge on read
   always_ff @(posedge r_clk or negedge r_rst_n) begin
      if (!r_rst_n) begin
         req_seen <= 1'b0;
         r_full   <= 1'b0;
         r_data   <= '0;
         ack_t    <= 1'b0;
      end else begin
         req_seen <= req_r;
         if (req_r != req_seen) begin
            r_full <= 1'b1;
            r_data <= s_hold;
         end else if (r_take && r_full) begin
            r_full <= 1'b0;
            ack_t  <= ~ack_t;
         end
      end
   end

   // R2
   busy_rise_chk: assert property (@(posedge s_clk) disable iff (!s_rst_n)
      $rose(s_busy) |-> $past(s_load));
   // R5
   hold_frozen_chk: assert property (@(posedge s_clk) disable iff (!s_rst_n)
      (s_busy && $past(s_busy)) |-> $stable(s_hold));
   // R3
   full_fall_chk: assert property (@(posedge r_clk) disable iff (!r_rst_n)
      $fell(r_full) |-> $past(r_take));
endmodule

// File: rtl/mbx_bell.sv
module mbx_bell #(
   parameter int unsigned N = 4
) (
   input  logic         s_clk,
   input  logic         s_rst_n,
   input  logic [N-1:0] s_ring,
   input  logic         r_clk,
   input  logic         r_rst_n,
   input  logic [N-1:0] r_clr,
   output logic [N-1:0] r_pend
);
   logic [N-1:0] tog, tog_r, tog_seen, hit;

   mbx_sync2 #(.W(N)) u_sync (.clk(r_clk), .rst_n(r_rst_n), .d(tog), .q(tog_r));

   always_ff @(posedge s_clk or negedge s_rst_n) begin
      if (!s_rst_n) tog <= '0;
      else          tog <= tog ^ s_ring;
   end

   assign hit = tog_r ^ tog_seen;

   always_ff @(posedge r_clk or negedge r_rst_n) begin
      if (!r_rst_n) begin
         tog_seen <= '0;
         r_pend   <= '0;
      end else begin
         tog_seen <= tog_r;
         r_pend   <= (r_pend & ~r_clr) | hit;
      end
   end

   for (genvar i = 0; i < N; i++) begin : g_chk
      // R6
      pend_fall_chk: assert property (@(posedge r_clk) disable iff (!r_rst_n)
         $fell(r_pend[i]) |-> $past(r_clr[i]));
   end
endmodule

// File: rtl/mbx_side.sv
module mbx_side
   import mbx_pkg::*;
#(
   parameter int unsigned NCH    = 4,
   parameter int unsigned DW     = 32,
   parameter bit          SIDE_B = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cs,
   input  logic                    we,
   input  logic [MBX_AW-1:0]       addr,
   input  logic [DW-1:0]           wdata,
   output logic [DW-1:0]           rdata,
   output logic                    irq,
   output logic [NCH-1:0]          tx_load,
   input  logic [NCH-1:0]          tx_busy,
   input  logic [NCH-1:0]          tx_done,
   input  logic [NCH-1:0][DW-1:0]  tx_hold,
   output logic [NCH-1:0]          rx_take,
   input  logic [NCH-1:0]          rx_full,
   input  logic [NCH-1:0][DW-1:0]  rx_data,
   output logic [NCH-1:0]          ring,
   output logic [NCH-1:0]          bell_clr,
   input  logic [NCH-1:0]          bell_pend
);
   localparam int unsigned AW  = MBX_AW;
   localparam int unsigned EW  = 3 * NCH;
   localparam int unsigned PAD = DW - 1 - NFLD * NCH;

   logic            wr, rd, stat_wr;
   logic [NCH-1:0]  ack_p, ovf, w1c_ack, w1c_ovf;
   logic [EW-1:0]   en;
   logic [DW-1:0]   status;

   assign wr      = cs && we;
   assign rd      = cs && !we;
   assign stat_wr = wr && (addr == AW'(ADR_STAT));

   for (genvar n = 0; n < NCH; n++) begin : g_dec
      assign tx_load[n] = wr && (addr == AW'(ADR_TX_BASE + n));
      assign rx_take[n] = rd && (addr == AW'(ADR_RX_BASE + n));
   end

   assign w1c_ack  = stat_wr ? wdata[FLD_ACK*NCH +: NCH] : '0;
   assign bell_clr = stat_wr ? wdata[FLD_DB*NCH  +: NCH] : '0;
   assign w1c_ovf  = stat_wr ? wdata[FLD_OVF*NCH +: NCH] : '0;
   assign ring     = (wr && (addr == AW'(ADR_RING))) ? wdata[NCH-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_p <= '0;
         ovf   <= '0;
         en    <= '0;
      end else begin
         ack_p <= (ack_p & ~w1c_ack) | tx_done;
         ovf   <= (ovf & ~w1c_ovf) | (tx_load & tx_busy);
         if (wr && (addr == AW'(ADR_EN))) en <= wdata[EW-1:0];
      end
   end

   assign status = {SIDE_B, {PAD{1'b0}}, ovf, bell_pend, ack_p, tx_busy, rx_full};

   always_comb begin
      rdata = '0;
      for (int n = 0; n < NCH; n++) begin
         if (addr == AW'(ADR_TX_BASE + n)) rdata = tx_hold[n];
         if (addr == AW'(ADR_RX_BASE + n)) rdata = rx_data[n];
      end
      if (addr == AW'(ADR_STAT)) rdata = status;
      if (addr == AW'(ADR_EN))   rdata = DW'(en);
   end

   assign irq = |({bell_pend, ack_p, rx_full} & en);

   for (genvar n = 0; n < NCH; n++) begin : g_chk
      // R3
      ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ack_p[n]) |-> $past(tx_done[n]));
   end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
   import mbx_pkg::*;
#(
   parameter int unsigned NCH = 4,
   parameter int unsigned DW  = 32
) (
   input  logic              clk_a,
   input  logic              rst_a_n,
   input  logic              a_cs,
   input  logic              a_we,
   input  logic [MBX_AW-1:0] a_addr,
   input  logic [DW-1:0]     a_wdata,
   output logic [DW-1:0]     a_rdata,
   output logic              a_irq,
   input  logic              clk_b,
   input  logic              rst_b_n,
   input  logic              b_cs,
   input  logic              b_we,
   input  logic [MBX_AW-1:0] b_addr,
   input  logic [DW-1:0]     b_wdata,
   output logic [DW-1:0]     b_rdata,
   output logic              b_irq
);
   if (NCH < 1 || NCH > 8) begin : g_bad_nch
      $error("ipc_mailbox: NCH must lie in 1..8");
   end
   if (DW < NFLD * NCH + 1) begin : g_bad_dw
      $error("ipc_mailbox: DW too narrow for the status layout");
   end

   logic [NCH-1:0]          a_tx_load, a_tx_busy, a_tx_done, a_rx_take, a_rx_full;
   logic [NCH-1:0]          b_tx_load, b_tx_busy, b_tx_done, b_rx_take, b_rx_full;
   logic [NCH-1:0][DW-1:0]  a_tx_hold, a_rx_data, b_tx_hold, b_rx_data;
   logic [NCH-1:0]          a_ring, a_clr, a_pend, b_ring, b_clr, b_pend;

   mbx_side #(.NCH(NCH), .DW(DW), .SIDE_B(1'b0)) u_side_a (
      .clk(clk_a), .rst_n(rst_a_n), .cs(a_cs), .we(a_we), .addr(a_addr),
      .wdata(a_wdata), .rdata(a_rdata), .irq(a_irq),
      .tx_load(a_tx_load), .tx_busy(a_tx_busy), .tx_done(a_tx_done), .tx_hold(a_tx_hold),
      .rx_take(a_rx_take), .rx_full(a_rx_full), .rx_data(a_rx_data),
      .ring(a_ring), .bell_clr(a_clr), .bell_pend(a_pend));

   mbx_side #(.NCH(NCH), .DW(DW), .SIDE_B(1'b1)) u_side_b (
      .clk(clk_b), .rst_n(rst_b_n), .cs(b_cs), .we(b_we), .addr(b_addr),
      .wdata(b_wdata), .rdata(b_rdata), .irq(b_irq),
      .tx_load(b_tx_load), .tx_busy(b_tx_busy), .tx_done(b_tx_done), .tx_hold(b_tx_hold),
      .rx_take(b_rx_take), .rx_full(b_rx_full), .rx_data(b_rx_data),
      .ring(b_ring), .bell_clr(b_clr), .bell_pend(b_pend));

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      mbx_xfer #(.DW(DW)) u_a2b (
         .s_clk(clk_a), .s_rst_n(rst_a_n), .s_load(a_tx_load[ch]), .s_data(a_wdata),
         .s_busy(a_tx_busy[ch]), .s_done(a_tx_done[ch]), .s_hold(a_tx_hold[ch]),
         .r_clk(clk_b), .r_rst_n(rst_b_n), .r_take(b_rx_take[ch]),
         .r_full(b_rx_full[ch]), .r_data(b_rx_data[ch]));
      mbx_xfer #(.DW(DW)) u_b2a (
         .s_clk(clk_b), .s_rst_n(rst_b_n), .s_load(b_tx_load[ch]), .s_data(b_wdata),
         .s_busy(b_tx_busy[ch]), .s_done(b_tx_done[ch]), .s_hold(b_tx_hold[ch]),
         .r_clk(clk_a), .r_rst_n(rst_a_n), .r_take(a_rx_take[ch]),
         .r_full(a_rx_full[ch]), .r_data(a_rx_data[ch]));
   end

   mbx_bell #(.N(NCH)) u_bell_a2b (
      .s_clk(clk_a), .s_rst_n(rst_a_n), .s_ring(a_ring),
      .r_clk(clk_b), .r_rst_n(rst_b_n), .r_clr(b_clr), .r_pend(b_pend));
   mbx_bell #(.N(NCH)) u_bell_b2a (
      .s_clk(clk_b), .s_rst_n(rst_b_n), .s_ring(b_ring),
      .r_clk(clk_a), .r_rst_n(rst_a_n), .r_clr(a_clr), .r_pend(a_pend));
endmodule

// File: tb/sim_ipc_mailbox.sv
module sim_ipc_mailbox;
   logic        clk_a = 1'b0, clk_b = 1'b0;
   logic        rst_a_n = 1'b0, rst_b_n = 1'b0;
   logic        a_cs = 1'b0, a_we = 1'b0, b_cs = 1'b0, b_we = 1'b0;
   logic [4:0]  a_addr = '0, b_addr = '0;
   logic [31:0] a_wdata = '0, b_wdata = '0;
   logic [31:0] a_rdata, b_rdata;
   logic        a_irq, b_irq;
   int          checks = 0, errors = 0;

   always #10 clk_a = ~clk_a;   // 50 MHz
   always #13 clk_b = ~clk_b;   // unrelated peer clock

   ipc_mailbox u0 (
      .clk_a(clk_a), .rst_a_n(rst_a_n), .a_cs(a_cs), .a_we(a_we), .a_addr(a_addr),
      .a_wdata(a_wdata), .a_rdata(a_rdata), .a_irq(a_irq),
      .clk_b(clk_b), .rst_b_n(rst_b_n), .b_cs(b_cs), .b_we(b_we), .b_addr(b_addr),
      .b_wdata(b_wdata), .b_rdata(b_rdata), .b_irq(b_irq));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input bit side_b, input logic [4:0] ad, input logic [31:0] d);
      if (!side_b) begin
         @(negedge clk_a); a_cs = 1; a_we = 1; a_addr = ad; a_wdata = d;
         @(negedge clk_a); a_cs = 0; a_we = 0;
      end else begin
         @(negedge clk_b); b_cs = 1; b_we = 1; b_addr = ad; b_wdata = d;
         @(negedge clk_b); b_cs = 0; b_we = 0;
      end
   endtask

   task automatic rd(input bit side_b, input logic [4:0] ad, output logic [31:0] d);
      if (!side_b) begin
         @(negedge clk_a); a_cs = 1; a_we = 0; a_addr = ad; #1 d = a_rdata;
         @(negedge clk_a); a_cs = 0;
      end else begin
         @(negedge clk_b); b_cs = 1; b_we = 0; b_addr = ad; #1 d = b_rdata;
         @(negedge clk_b); b_cs = 0;
      end
   endtask

   task automatic settle();
      repeat (10) @(negedge clk_b);
      repeat (10) @(negedge clk_a);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(0, 16, v); chk("R1 A status after reset", v, 32'h0);
      rd(1, 16, v); chk("R1 B status after reset", v, 32'h8000_0000);
      rd(0, 17, v); chk("R1 A enable after reset", v, 32'h0);
      rd(1, 17, v); chk("R1 B enable after reset", v, 32'h0);
      chk("R1 irq low after reset", {30'h0, a_irq, b_irq}, 32'h0);
   endtask

   task automatic t_side_bit();
      logic [31:0] v;
      rd(0, 16, v); chk("R9 A side bit", {31'h0, v[31]}, 32'h0);
      rd(1, 16, v); chk("R9 B side bit", {31'h0, v[31]}, 32'h1);
   endtask

   task automatic t_a2b();
      logic [31:0] v;
      wr(0, 0, 32'hDEAD_BEEF);
      rd(0, 16, v); chk("R2 A tx full ch0", {31'h0, v[4]}, 32'h1);
      settle();
      rd(1, 16, v); chk("R2 B rx full ch0", v[3:0], 4'h1);
      rd(1, 8, v);  chk("R2 B rx ch0 data", v, 32'hDEAD_BEEF);
      rd(1, 16, v); chk("R3 B rx full clear", v[3:0], 4'h0);
      settle();
      rd(0, 16, v); chk("R3 A tx full clear, ack set", v[11:4], 8'h10);
      wr(0, 16, 32'h0000_0100);
      rd(0, 16, v); chk("R6 A ack W1C clear", v[11:8], 4'h0);
   endtask

   task automatic t_empty_read();
      logic [31:0] v;
      rd(1, 8, v); chk("R4 empty read keeps last word", v, 32'hDEAD_BEEF);
      settle();
      rd(0, 16, v); chk("R4 no ack from empty read", v[11:4], 8'h00);
   endtask

   task automatic t_both_dirs();
      logic [31:0] v;
      wr(0, 1, 32'hA5A5_0001);
      wr(1, 2, 32'h1234_5678);
      wr(0, 2, 32'h0BAD_F00D);
      settle();
      rd(1, 16, v); chk("R10 B rx full ch1,ch2", v[3:0], 4'h6);
      rd(0, 16, v); chk("R10 A rx full ch2", v[3:0], 4'h4);
      rd(1, 9, v);  chk("R10 B rx ch1", v, 32'hA5A5_0001);
      rd(1, 10, v); chk("R10 B rx ch2", v, 32'h0BAD_F00D);
      rd(0, 10, v); chk("R10 A rx ch2", v, 32'h1234_5678);
      settle();
      rd(0, 16, v); chk("R10 A ack ch1,ch2", v[11:4], 8'h60);
      rd(1, 16, v); chk("R10 B ack ch2", v[11:4], 8'h40);
      wr(0, 16, 32'h0000_0F00);
      wr(1, 16, 32'h0000_0F00);
   endtask

   task automatic t_overflow();
      logic [31:0] v;
      wr(0, 3, 32'h1111_0003);
      wr(0, 3, 32'h2222_0003);
      rd(0, 16, v); chk("R5 A overflow ch3 set", {31'h0, v[19]}, 32'h1);
      settle();
      rd(1, 11, v); chk("R5 B rx ch3 first word kept", v, 32'h1111_0003);
      settle();
      wr(0, 16, 32'h0008_0800);
      rd(0, 16, v); chk("R6 A overflow and ack W1C", v[19:8], 12'h000);
   endtask

   task automatic t_irq();
      logic [31:0] v;
      wr(0, 17, 32'h0000_0010);
      chk("R8 A irq low, ack not pending", {31'h0, a_irq}, 32'h0);
      wr(1, 17, 32'h0000_0001);
      wr(0, 0, 32'h0000_0005);
      settle();
      chk("R8 B irq on rx full ch0", {31'h0, b_irq}, 32'h1);
      rd(1, 8, v);
      chk("R8 B irq low after read", {31'h0, b_irq}, 32'h0);
      settle();
      chk("R8 A irq on ack ch0", {31'h0, a_irq}, 32'h1);
      wr(0, 16, 32'h0000_0100);
      chk("R8 A irq low after clear", {31'h0, a_irq}, 32'h0);
      wr(0, 17, 32'h0);
      wr(1, 17, 32'h0);
   endtask

   task automatic t_doorbell();
      logic [31:0] v;
      wr(0, 18, 32'h0000_0005);
      settle();
      rd(1, 16, v); chk("R7 B doorbell pend", v[15:12], 4'h5);
      chk("R7 B no rx full from bell", v[3:0], 4'h0);
      wr(1, 17, 32'h0000_0400);
      chk("R8 B irq on doorbell 2", {31'h0, b_irq}, 32'h1);
      wr(1, 16, 32'h0000_1000);
      rd(1, 16, v); chk("R6 B doorbell W1C one bit", v[15:12], 4'h4);
      wr(1, 16, 32'h0000_4000);
      chk("R8 B irq low after bell clear", {31'h0, b_irq}, 32'h0);
      wr(1, 18, 32'h0000_0008);
      settle();
      rd(0, 16, v); chk("R7 A doorbell pend ch3", v[15:12], 4'h8);
   endtask

   initial begin
      repeat (4) @(negedge clk_b);
      rst_a_n = 1'b1;
      rst_b_n = 1'b1;
      repeat (3) @(negedge clk_b);
      t_reset();
      t_side_bit();
      t_a2b();
      t_empty_read();
      t_both_dirs();
      t_overflow();
      t_irq();
      t_doorbell();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk_a);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule